// File: doc/BRIEF.md
# DMA Channel Event and Wait Unit

This unit holds a bank of event flags that a host and one DMA channel share. The host raises a flag by writing its index. The channel can ask to wait on an event. If the flag is already raised, the wait completes after exactly one stall cycle, and the unit lowers the flag as it completes. If the flag is low, the channel stalls until the host raises it. The channel can also send an event, which sets a sticky interrupt bit for that index. The host clears interrupt bits by writing ones.

A wait may carry an invalidate qualifier. When such a wait completes, the unit pulses a flush output toward the channel's instruction cache for one cycle. A kill input abandons a pending wait and leaves the flags alone. Every request sits on the channel port until ready is seen high at a clock edge.

Top module: `evt_unit`

## Requirements
- R1: A wait on an index whose flag is low keeps ch_req_ready low until the host sets that flag. ch_req_ready then goes high in the cycle after the host write edge.
- R2: A wait on an index whose flag is already high shows ch_req_ready low in the first request cycle and high in the second.
- R3: A completed wait lowers the flag it named, so a second wait on that index stalls until a new host write.
- R4: A send request (ch_req_op = 1) is accepted with ch_req_ready high in its first cycle. The irq bit for its index is high from the next cycle and stays high. irq resets to all zeros.
- R5: Writing a 1 in bit k of irq_clr lowers irq[k] on the next cycle. If a send to index k lands in the same cycle as that clear, the bit stays high.
- R6: When a wait (ch_req_op = 0) completes with ch_req_inval high, icache_flush is high for exactly the one cycle after the completing edge. A wait without the qualifier never raises it.
- R7: There are NUM_EVENTS (default 8, at least 5) independent flags. A raised flag on one index never releases a wait on another index.
- R8: If the host sets a flag in the same cycle that a wait consumes it, the flag stays set.
- R9: ch_kill holds ch_req_ready low and returns the unit to idle. The flags are unchanged: a flag set before the kill is still set, and the abandoned wait's flag is still low.
- R10: Setting an already raised flag does not stack. One wait consumes it, and the next wait on that index stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_set_valid | input | 1 | Host write that raises a flag |
| host_set_idx | input | IDX_W | Index of the flag to raise |
| irq_clr | input | NUM_EVENTS | Write-one-to-clear mask for irq |
| ch_req_valid | input | 1 | Channel request present |
| ch_req_op | input | 1 | 0 = wait for event, 1 = send event |
| ch_req_idx | input | IDX_W | Event index of the request |
| ch_req_inval | input | 1 | Wait also flushes the instruction cache |
| ch_kill | input | 1 | Abandon any pending wait |
| ch_req_ready | output | 1 | Request accepted at this edge (low = stall) |
| irq | output | NUM_EVENTS | Sticky interrupt bits, one per event |
| icache_flush | output | 1 | One-cycle cache flush pulse |

## Verification
The bench builds the unit with NUM_EVENTS = 8 and FLUSH_EN = 1. With these values the highest index, 7, lies outside the five-event minimum, so the full 3-bit index decode is exercised. The flush pulse is also built, so both qualified and unqualified waits can be compared. Waits are run in both orders relative to the host write. The bench also drives a host set in the same cycle as a consume, a send in the same cycle as a clear, and a kill during a stall. Each of these races shows up at the ports as a measured stall length or an interrupt bit value.

// File: rtl/evt_pkg.sv
package evt_pkg;
   typedef enum logic {
      EVT_OP_WAIT = 1'b0,
      EVT_OP_SEND = 1'b1
   } evt_op_e;

   typedef enum logic {
      WS_IDLE = 1'b0,
      WS_HOLD = 1'b1
   } wstate_e;
endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
   parameter int NUM_EVENTS = 8,
   parameter int IDX_W      = $clog2(NUM_EVENTS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  set_valid,
   input  logic [IDX_W-1:0]      set_idx,
   input  logic                  clr_valid,
   input  logic [IDX_W-1:0]      clr_idx,
   output logic [NUM_EVENTS-1:0] flags
);
   for (genvar k = 0; k < NUM_EVENTS; k++) begin : g_flag
      logic set_hit;
      logic clr_hit;
      assign set_hit = set_valid && (set_idx == IDX_W'(k));
      assign clr_hit = clr_valid && (clr_idx == IDX_W'(k));
      // a host write beats a consume in the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       flags[k] <= 1'b0;
         else if (set_hit) flags[k] <= 1'b1;
         else if (clr_hit) flags[k] <= 1'b0;
      end
   end
endmodule

// File: rtl/evt_irq_bank.sv
module evt_irq_bank #(
   parameter int NUM_EVENTS = 8,
   parameter int IDX_W      = $clog2(NUM_EVENTS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  send_valid,
   input  logic [IDX_W-1:0]      send_idx,
   input  logic [NUM_EVENTS-1:0] clr_mask,
   output logic [NUM_EVENTS-1:0] irq
);
   for (genvar k = 0; k < NUM_EVENTS; k++) begin : g_irq
      logic raise;
      assign raise = send_valid && (send_idx == IDX_W'(k));
      // a send beats a clear in the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           irq[k] <= 1'b0;
         else if (raise)       irq[k] <= 1'b1;
         else if (clr_mask[k]) irq[k] <= 1'b0;
      end
   end
endmodule

// File: rtl/evt_wait_ctrl.sv
module evt_wait_ctrl
   import evt_pkg::*;
#(
   parameter int NUM_EVENTS = 8,
   parameter int IDX_W      = $clog2(NUM_EVENTS),
   parameter bit FLUSH_EN   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  evt_op_e               req_op,
   input  logic [IDX_W-1:0]      req_idx,
   input  logic                  req_inval,
   input  logic                  kill,
   input  logic [NUM_EVENTS-1:0] flags,
   output logic                  req_ready,
   output logic                  consume_valid,
   output logic [IDX_W-1:0]      consume_idx,
   output logic                  consume_inval,
   output logic                  send_valid,
   output logic                  busy,
   output logic                  flush
);
   wstate_e          state_q, state_d;
   logic [IDX_W-1:0] idx_q;
   logic             inval_q;
   logic             capture;

   assign capture = (state_q == WS_IDLE) && req_valid && (req_op == EVT_OP_WAIT) && !kill;

   always_comb begin
      state_d       = state_q;
      req_ready     = 1'b0;
      consume_valid = 1'b0;
      send_valid    = 1'b0;
      if (kill) begin
         state_d = WS_IDLE;
      end else begin
         unique case (state_q)
            WS_IDLE: begin
               if (req_valid) begin
                  if (req_op == EVT_OP_SEND) begin
                     req_ready  = 1'b1;
                     send_valid = 1'b1;
                  end else begin
                     state_d = WS_HOLD;
                  end
               end
            end
            WS_HOLD: begin
               if (flags[idx_q]) begin
                  req_ready     = 1'b1;
                  consume_valid = 1'b1;
                  state_d       = WS_IDLE;
               end
            end
            default: state_d = WS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WS_IDLE;
         idx_q   <= '0;
         inval_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (capture) begin
            idx_q   <= req_idx;
            inval_q <= req_inval;
         end
      end
   end

   assign consume_idx   = idx_q;
   assign consume_inval = inval_q;
   assign busy          = (state_q == WS_HOLD);

   if (FLUSH_EN) begin : g_flush
      logic flush_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flush_q <= 1'b0;
         else        flush_q <= consume_valid && inval_q;
      end
      assign flush = flush_q;
   end else begin : g_noflush
      assign flush = 1'b0;
   end
endmodule

// File: rtl/evt_unit.sv
module evt_unit
   import evt_pkg::*;
#(
   parameter int NUM_EVENTS = 8,
   parameter bit FLUSH_EN   = 1'b1,
   localparam int IDX_W     = $clog2(NUM_EVENTS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  host_set_valid,
   input  logic [IDX_W-1:0]      host_set_idx,
   input  logic [NUM_EVENTS-1:0] irq_clr,
   input  logic                  ch_req_valid,
   input  logic                  ch_req_op,
   input  logic [IDX_W-1:0]      ch_req_idx,
   input  logic                  ch_req_inval,
   input  logic                  ch_kill,
   output logic                  ch_req_ready,
   output logic [NUM_EVENTS-1:0] irq,
   output logic                  icache_flush
);
   if (NUM_EVENTS < 5) begin : g_bad_count
      $error("evt_unit: NUM_EVENTS must be at least 5");
   end
   if ((1 << IDX_W) != NUM_EVENTS) begin : g_bad_pow2
      $error("evt_unit: NUM_EVENTS must be a power of two");
   end

   logic [NUM_EVENTS-1:0] flags;
   logic                  wait_done;
   logic [IDX_W-1:0]      wait_idx;
   logic                  wait_inval;
   logic                  send_fire;
   logic                  busy;

   evt_wait_ctrl #(
      .NUM_EVENTS (NUM_EVENTS),
      .IDX_W      (IDX_W),
      .FLUSH_EN   (FLUSH_EN)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (ch_req_valid),
      .req_op        (evt_op_e'(ch_req_op)),
      .req_idx       (ch_req_idx),
      .req_inval     (ch_req_inval),
      .kill          (ch_kill),
      .flags         (flags),
      .req_ready     (ch_req_ready),
      .consume_valid (wait_done),
      .consume_idx   (wait_idx),
      .consume_inval (wait_inval),
      .send_valid    (send_fire),
      .busy          (busy),
      .flush         (icache_flush)
   );

   evt_flag_bank #(
      .NUM_EVENTS (NUM_EVENTS),
      .IDX_W      (IDX_W)
   ) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_valid (host_set_valid),
      .set_idx   (host_set_idx),
      .clr_valid (wait_done),
      .clr_idx   (wait_idx),
      .flags     (flags)
   );

   evt_irq_bank #(
      .NUM_EVENTS (NUM_EVENTS),
      .IDX_W      (IDX_W)
   ) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .send_valid (send_fire),
      .send_idx   (ch_req_idx),
      .clr_mask   (irq_clr),
      .irq        (irq)
   );
endmodule

// File: rtl/evt_unit_chk.sv
module evt_unit_chk #(
   parameter int NUM_EVENTS = 8,
   parameter bit FLUSH_EN   = 1'b1,
   parameter int IDX_W      = $clog2(NUM_EVENTS)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  host_set_valid,
   input logic [IDX_W-1:0]      host_set_idx,
   input logic [NUM_EVENTS-1:0] irq_clr,
   input logic                  ch_req_idx_dummy,
   input logic [IDX_W-1:0]      ch_req_idx,
   input logic                  ch_kill,
   input logic                  ch_req_ready,
   input logic [NUM_EVENTS-1:0] irq,
   input logic                  icache_flush,
   input logic [NUM_EVENTS-1:0] flags,
   input logic                  wait_done,
   input logic [IDX_W-1:0]      wait_idx,
   input logic                  wait_inval,
   input logic                  send_fire,
   input logic                  busy
);
   logic [NUM_EVENTS-1:0] send_vec;
   logic                  set_same;
   logic                  unused_ok;

   assign send_vec  = send_fire ? (NUM_EVENTS'(1) << ch_req_idx) : '0;
   assign set_same  = host_set_valid && (host_set_idx == wait_idx);
   assign unused_ok = ch_req_idx_dummy;

   // R1: a pending wait on a low flag is stalled
   p_stall_low_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !flags[wait_idx] |-> !ch_req_ready);

   // R2: entering the wait with the flag already high releases immediately
   p_one_cycle_consume_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) && flags[wait_idx] && !ch_kill |-> ch_req_ready);

   // R3: a completed wait leaves its flag low unless the host re-raised it
   p_flag_consumed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wait_done && !set_same |=> !flags[$past(wait_idx)]);

   // R4: a send raises the matching interrupt bit
   p_send_raises_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      send_fire |=> irq[$past(ch_req_idx)]);

   // R5: cleared bits not re-sent go low
   p_irq_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_clr) |=> ((irq & $past(irq_clr & ~send_vec)) == '0));

   if (FLUSH_EN) begin : g_flush_chk
      // R6: flush follows a completing invalidate wait, and nothing else
      p_flush_after_inval_r6: assert property (@(posedge clk) disable iff (!rst_n)
         wait_done && wait_inval |=> icache_flush);
      p_flush_only_after_inval_r6: assert property (@(posedge clk) disable iff (!rst_n)
         icache_flush |-> $past(wait_done && wait_inval));
   end

   // R8: a host write always leaves its flag raised
   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      host_set_valid |=> flags[$past(host_set_idx)]);

   // R9: kill returns to idle and leaves the flags as they were
   p_kill_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ch_kill |=> !busy);
   p_kill_no_flag_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ch_kill && !host_set_valid |=> flags == $past(flags));
   p_kill_no_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ch_kill |-> !ch_req_ready);
endmodule

bind evt_unit evt_unit_chk #(
   .NUM_EVENTS (NUM_EVENTS),
   .FLUSH_EN   (FLUSH_EN),
   .IDX_W      (IDX_W)
) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .host_set_valid   (host_set_valid),
   .host_set_idx     (host_set_idx),
   .irq_clr          (irq_clr),
   .ch_req_idx_dummy (ch_req_valid),
   .ch_req_idx       (ch_req_idx),
   .ch_kill          (ch_kill),
   .ch_req_ready     (ch_req_ready),
   .irq              (irq),
   .icache_flush     (icache_flush),
   .flags            (flags),
   .wait_done        (wait_done),
   .wait_idx         (wait_idx),
   .wait_inval       (wait_inval),
   .send_fire        (send_fire),
   .busy             (busy)
);

// File: tb/test_evt_unit.sv
`timescale 1ns/1ps
module test_evt_unit;
   localparam int N  = 8;
   localparam int IW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_set_valid = 1'b0;
   logic [IW-1:0] host_set_idx = '0;
   logic [N-1:0]  irq_clr = '0;
   logic          ch_req_valid = 1'b0;
   logic          ch_req_op = 1'b0;
   logic [IW-1:0] ch_req_idx = '0;
   logic          ch_req_inval = 1'b0;
   logic          ch_kill = 1'b0;
   logic          ch_req_ready;
   logic [N-1:0]  irq;
   logic          icache_flush;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   evt_unit #(.NUM_EVENTS(N), .FLUSH_EN(1'b1)) i_evt_unit (
      .clk(clk), .rst_n(rst_n),
      .host_set_valid(host_set_valid), .host_set_idx(host_set_idx),
      .irq_clr(irq_clr),
      .ch_req_valid(ch_req_valid), .ch_req_op(ch_req_op),
      .ch_req_idx(ch_req_idx), .ch_req_inval(ch_req_inval),
      .ch_kill(ch_kill), .ch_req_ready(ch_req_ready),
      .irq(irq), .icache_flush(icache_flush)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // every task starts and ends just after a falling edge
   task automatic host_pulse(input int idx);
      host_set_valid = 1'b1;
      host_set_idx   = IW'(idx);
      @(negedge clk);
      host_set_valid = 1'b0;
   endtask

   task automatic drive_wait(input int idx, input bit inval);
      ch_req_valid = 1'b1;
      ch_req_op    = 1'b0;
      ch_req_idx   = IW'(idx);
      ch_req_inval = inval;
   endtask

   // wait on a raised flag; measure stall cycles before ready
   task automatic wait_expect(input int idx, input bit inval, input int exp_stall, input string tag);
      int stall = 0;
      drive_wait(idx, inval);
      for (int c = 0; c < 20; c++) begin
         #1;
         if (ch_req_ready) break;
         stall++;
         @(negedge clk);
      end
      @(negedge clk);
      ch_req_valid = 1'b0;
      chk(tag, stall, exp_stall);
   endtask

   // wait on a low flag: stays stalled, released one cycle after host write
   task automatic pending_then_set(input int idx, input string tag);
      drive_wait(idx, 1'b0);
      for (int c = 0; c < 3; c++) begin
         #1 chk({tag, " stall"}, ch_req_ready, 1'b0);
         @(negedge clk);
      end
      host_set_valid = 1'b1;
      host_set_idx   = IW'(idx);
      #1 chk({tag, " stall at set"}, ch_req_ready, 1'b0);
      @(negedge clk);
      host_set_valid = 1'b0;
      #1 chk({tag, " release"}, ch_req_ready, 1'b1);
      @(negedge clk);
      ch_req_valid = 1'b0;
   endtask

   task automatic send_evt(input int idx, input logic [N-1:0] clr);
      ch_req_valid = 1'b1;
      ch_req_op    = 1'b1;
      ch_req_idx   = IW'(idx);
      irq_clr      = clr;
      #1 chk("R4 send ready", ch_req_ready, 1'b1);
      @(negedge clk);
      ch_req_valid = 1'b0;
      ch_req_op    = 1'b0;
      irq_clr      = '0;
   endtask

   task automatic t_reset;
      #1;
      chk("R4 reset irq", irq, '0);
      chk("R6 reset flush", icache_flush, 1'b0);
      chk("R1 reset ready", ch_req_ready, 1'b0);
   endtask

   task automatic t_set_before_wait;
      host_pulse(2);
      wait_expect(2, 1'b0, 1, "R2 one-cycle consume");
      #1 chk("R6 no flush on plain wait", icache_flush, 1'b0);
      @(negedge clk);
   endtask

   task automatic t_wait_before_set;
      pending_then_set(5, "R1");
   endtask

   task automatic t_reconsume;
      pending_then_set(2, "R3");
   endtask

   task automatic t_double_set;
      host_pulse(0);
      host_pulse(0);
      wait_expect(0, 1'b0, 1, "R10 first wait");
      pending_then_set(0, "R10 second wait");
   endtask

   task automatic t_set_wins;
      drive_wait(3, 1'b0);
      @(negedge clk);
      @(negedge clk);
      host_set_valid = 1'b1;
      host_set_idx   = IW'(3);
      @(negedge clk);
      #1 chk("R8 release", ch_req_ready, 1'b1);
      @(negedge clk);
      host_set_valid = 1'b0;
      ch_req_valid   = 1'b0;
      wait_expect(3, 1'b0, 1, "R8 flag survived consume");
   endtask

   task automatic t_flush;
      host_pulse(4);
      wait_expect(4, 1'b1, 1, "R6 inval wait");
      #1 chk("R6 flush pulse", icache_flush, 1'b1);
      @(negedge clk);
      #1 chk("R6 flush one cycle", icache_flush, 1'b0);
      ch_req_inval = 1'b0;
   endtask

   task automatic t_send;
      send_evt(1, '0);
      #1 chk("R4 irq1", irq, 8'h02);
      send_evt(4, '0);
      #1 chk("R4 irq4", irq, 8'h12);
      @(negedge clk);
      @(negedge clk);
      #1 chk("R4 sticky", irq, 8'h12);
   endtask

   task automatic t_irq_clear;
      irq_clr = 8'h02;
      @(negedge clk);
      irq_clr = '0;
      #1 chk("R5 w1c", irq, 8'h10);
      send_evt(4, 8'h10);
      #1 chk("R5 send beats clear", irq, 8'h10);
      irq_clr = 8'hFF;
      @(negedge clk);
      irq_clr = '0;
      #1 chk("R5 clear all", irq, 8'h00);
   endtask

   task automatic t_kill;
      host_pulse(7);
      drive_wait(6, 1'b0);
      @(negedge clk);
      @(negedge clk);
      ch_kill = 1'b1;
      #1 chk("R9 no ready on kill", ch_req_ready, 1'b0);
      @(negedge clk);
      ch_kill      = 1'b0;
      ch_req_valid = 1'b0;
      #1 chk("R9 idle after kill", ch_req_ready, 1'b0);
      @(negedge clk);
      wait_expect(7, 1'b0, 1, "R9 set flag kept");
      pending_then_set(6, "R9 abandoned flag still low");
   endtask

   task automatic t_independent;
      host_pulse(1);
      pending_then_set(0, "R7 other flag ignored");
      wait_expect(1, 1'b0, 1, "R7 own flag");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      @(negedge clk);
      t_set_before_wait();
      t_wait_before_set();
      t_reconsume();
      t_double_set();
      t_set_wins();
      t_flush();
      t_send();
      t_irq_clear();
      t_kill();
      t_independent();
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #800000;
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule